// File: doc/BRIEF.md
# Serial Crate-Bus Command Slave

This block is the slave end of a bit-serial crate bus. The bus master drives a serial clock and a serial data line. Both are asynchronous to the board's system clock, so the block resynchronizes them and samples the data line on each rising edge of the resynchronized serial clock. A bus transaction is 64 serial clock edges long. In the first 32 edges the master sends a command frame, most-significant bit first. In the next 32 edges the slave may send a reply on its own output line.

The command frame has the following fields, in order:
- a constant 1 start bit;
- an odd parity bit;
- a power-down flag;
- a broadcast flag;
- an 8-bit select code;
- a read/write bit;
- a 3-bit section address;
- 16 data bits.

The block checks parity. It compares the select code with the board's own ID, or takes a broadcast write. It then turns the section address and the direction bit into a single one-cycle register strobe.

The reply has the following parts, in order:
- a constant 0 bit;
- an echo of the 15 header bits that follow the start bit;
- 16 bits of read data, taken from the register side.

The output is driven only while the block is replying. The register file behind the strobes and the line drivers are not part of this block.

Top module: `crate_cmd_slave`

## Requirements
- R1: Outside a transaction, the block starts a frame only when it samples a 1 on the data line at a rising serial clock edge. Samples of 0 there are skipped. Data sampled during the 32 reply-window edges that follow every frame is never taken as a frame.
- R2: Frame bits are sampled on the rising edges of the resynchronized serial clock, most-significant first. Sent as a 32-bit word, bit 31 is the start bit, bit 30 is parity, bit 29 is power-down, bit 28 is broadcast, bits 27:20 are the select code, bit 19 is read/write (0 = write, 1 = read), bits 18:16 are the section and bits 15:0 are data. `ser_dout` changes only in the cycle after a detected rising edge.
- R3: The number of ones in word bits 30:0 must be odd. If it is even, the frame gives no strobe, no reply and no change to `pwr_down`.
- R4: A frame with the broadcast flag clear is accepted only when its select code equals `board_id`. On a mismatch the frame gives no strobe and no reply.
- R5: An accepted write pulses `wr_stb[section]` for one system cycle, with the frame data on `wr_data`. An accepted read pulses `rd_stb[section]` for one cycle.
- R6: A write with the broadcast flag set is accepted whatever the select code is, and gives its strobe but no reply. A read with the broadcast flag set is dropped: no strobe and no reply.
- R7: The reply to an accepted addressed frame is a 0, then word bits 30:16 of the frame, then `rd_data` MSB first. `rd_data` is sampled at the edge that sends reply bit 16.
- R8: `ser_oe` is high for exactly the 32 reply edges of a replying frame and low otherwise. It falls at the first rising edge after the last reply bit. `ser_dout` is 0 whenever `ser_oe` is low, and no strobe coincides with `ser_oe`.
- R9: Section 4 (binary 100) is reserved. An accepted frame to it gives no strobe, but an addressed one still replies.
- R10: `pwr_down` takes the power-down flag of every accepted frame and holds it otherwise.
- R11: After reset, `ser_oe`, `ser_dout`, all strobes and `pwr_down` are 0.
- R12: A frame gives at most one strobe bit across `wr_stb` and `rd_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Bus serial clock, asynchronous |
| ser_din | input | 1 | Bus serial data from the master |
| board_id | input | 8 | Select code this slave answers to |
| rd_data | input | 16 | Read data from the register side |
| ser_dout | output | 1 | Serial reply data |
| ser_oe | output | 1 | Reply output enable (low = released) |
| wr_stb | output | 8 | One-hot write strobe per section |
| rd_stb | output | 8 | One-hot read strobe per section |
| wr_data | output | 16 | Write data that goes with `wr_stb` |
| pwr_down | output | 1 | Last accepted power-down flag |

## Verification
On every cycle the assertions check the following:
- strobes are one-hot and last a single cycle;
- no strobe occurs while the output is enabled;
- `ser_oe` changes only right after a serial edge;
- the reply data holds between serial edges;
- the output reads 0 while released;
- every reply opens with a 0.

Only the directed scenarios can show the frame-level behaviour. They show which field lands where, and that parity, select and broadcast decide acceptance correctly. They also show the echoed header and read data bit by bit, the reserved section, the power-down flag being kept across a rejected frame, and that a look-alike frame sent during the reply window is ignored.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int SEL_W  = 8;
  localparam int SEC_W  = 3;
  localparam int DAT_W  = 16;
  localparam int HDR_W  = 4 + SEL_W + 1 + SEC_W;
  localparam int FRM_W  = HDR_W + DAT_W;
  localparam int ECHO_W = HDR_W - 1;
  localparam int NSEC   = 1 << SEC_W;
  localparam int IDX_W  = $clog2(FRM_W + 1);

  // Field order follows the wire order, MSB first.
  typedef struct packed {
    logic             start;
    logic             par;
    logic             pd;
    logic             bc;
    logic [SEL_W-1:0] sel;
    logic             rw;
    logic [SEC_W-1:0] sec;
    logic [DAT_W-1:0] data;
  } cmd_frame_t;

  typedef enum logic [1:0] {RX_IDLE, RX_SHIFT, RX_HOLD} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_ARM, TX_SEND, TX_TAIL} tx_state_e;
endpackage

// File: rtl/ccs_sync.sv
module ccs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_a,
  input  logic sdin_a,
  output logic sclk_rise,
  output logic sdin_s
);
  logic [STAGES-1:0] sclk_q, sclk_q_n;
  logic [STAGES-1:0] din_q, din_q_n;
  logic              sclk_d, sclk_d_n;

  always_comb begin
    sclk_q_n = {sclk_q[STAGES-2:0], sclk_a};
    din_q_n  = {din_q[STAGES-2:0], sdin_a};
    sclk_d_n = sclk_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      din_q  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= sclk_q_n;
      din_q  <= din_q_n;
      sclk_d <= sclk_d_n;
    end
  end

  // Data travels through the same number of stages as the clock.
  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_d;
  assign sdin_s    = din_q[STAGES-1];
endmodule

// File: rtl/ccs_rx.sv
module ccs_rx
  import ccs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise,
  input  logic       sdin,
  input  logic       tx_tail,
  output logic       frame_vld,
  output cmd_frame_t frame
);
  rx_state_e        st, st_n;
  logic [IDX_W-1:0] cnt, cnt_n;
  logic [FRM_W-1:0] sr, sr_n;
  logic             vld, vld_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    sr_n  = sr;
    vld_n = 1'b0;
    case (st)
      RX_IDLE: begin
        if (rise && sdin) begin
          st_n  = RX_SHIFT;
          sr_n  = {sr[FRM_W-2:0], 1'b1};
          cnt_n = IDX_W'(1);
        end
      end
      RX_SHIFT: begin
        if (rise) begin
          sr_n = {sr[FRM_W-2:0], sdin};
          if (cnt == IDX_W'(FRM_W - 1)) begin
            st_n  = RX_HOLD;
            vld_n = 1'b1;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end
      RX_HOLD: begin
        // Reply window belongs to the transmitter; wait for its last slot.
        if (tx_tail) st_n = RX_IDLE;
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= RX_IDLE;
      cnt <= '0;
      sr  <= '0;
      vld <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      sr  <= sr_n;
      vld <= vld_n;
    end
  end

  assign frame_vld = vld;
  assign frame     = cmd_frame_t'(sr);
endmodule

// File: rtl/ccs_decode.sv
module ccs_decode
  import ccs_pkg::*;
#(
  parameter logic [NSEC-1:0] RSVD_MASK = NSEC'(1 << 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_vld,
  input  cmd_frame_t        frame,
  input  logic [SEL_W-1:0]  board_id,
  output logic [NSEC-1:0]   wr_stb,
  output logic [NSEC-1:0]   rd_stb,
  output logic [DAT_W-1:0]  wr_data,
  output logic              pwr_down,
  output logic              tx_start,
  output logic              tx_reply,
  output logic [ECHO_W-1:0] tx_echo
);
  logic [FRM_W-1:0]  fv;
  logic              par_ok, addressed, acc_wr, acc_rd;
  logic [NSEC-1:0]   sec_hit;

  logic [NSEC-1:0]   wr_stb_n, rd_stb_n;
  logic [DAT_W-1:0]  wr_data_n;
  logic              pwr_n, start_n, reply_n;
  logic [ECHO_W-1:0] echo_n;

  assign fv        = frame;
  assign par_ok    = (^fv[FRM_W-2:0]) & frame.start;
  assign addressed = !frame.bc && (frame.sel == board_id);
  assign acc_wr    = frame_vld && par_ok && !frame.rw && (addressed || frame.bc);
  assign acc_rd    = frame_vld && par_ok && frame.rw && addressed;

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    assign sec_hit[g] = (frame.sec == SEC_W'(g)) && !RSVD_MASK[g];
  end

  always_comb begin
    wr_stb_n  = acc_wr ? sec_hit : '0;
    rd_stb_n  = acc_rd ? sec_hit : '0;
    wr_data_n = acc_wr ? frame.data : wr_data;
    pwr_n     = (acc_wr || acc_rd) ? frame.pd : pwr_down;
    start_n   = frame_vld;
    reply_n   = frame_vld ? (par_ok && addressed) : tx_reply;
    echo_n    = frame_vld ? fv[FRM_W-2 -: ECHO_W] : tx_echo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb   <= '0;
      rd_stb   <= '0;
      wr_data  <= '0;
      pwr_down <= 1'b0;
      tx_start <= 1'b0;
      tx_reply <= 1'b0;
      tx_echo  <= '0;
    end else begin
      wr_stb   <= wr_stb_n;
      rd_stb   <= rd_stb_n;
      wr_data  <= wr_data_n;
      pwr_down <= pwr_n;
      tx_start <= start_n;
      tx_reply <= reply_n;
      tx_echo  <= echo_n;
    end
  end
endmodule

// File: rtl/ccs_tx.sv
module ccs_tx
  import ccs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              start,
  input  logic              reply,
  input  logic [ECHO_W-1:0] echo,
  input  logic [DAT_W-1:0]  rd_data,
  output logic              sdout,
  output logic              soe,
  output logic              tail
);
  tx_state_e         st, st_n;
  logic [IDX_W-1:0]  idx, idx_n;
  logic [ECHO_W-1:0] echo_sr, echo_sr_n;
  logic [DAT_W-1:0]  dat_sr, dat_sr_n;
  logic              rep_q, rep_n;
  logic              dout, dout_n;
  logic              oe, oe_n;
  logic              bit_v;

  always_comb begin
    st_n      = st;
    idx_n     = idx;
    echo_sr_n = echo_sr;
    dat_sr_n  = dat_sr;
    rep_n     = rep_q;
    dout_n    = dout;
    oe_n      = oe;
    bit_v     = 1'b0;
    case (st)
      TX_IDLE: begin
        if (start) begin
          st_n      = TX_ARM;
          echo_sr_n = echo;
          rep_n     = reply;
        end
      end
      TX_ARM: begin
        if (rise) begin
          st_n   = TX_SEND;
          dout_n = 1'b0;
          oe_n   = rep_q;
          idx_n  = IDX_W'(1);
        end
      end
      TX_SEND: begin
        if (rise) begin
          if (idx < IDX_W'(HDR_W)) begin
            bit_v     = echo_sr[ECHO_W-1];
            echo_sr_n = {echo_sr[ECHO_W-2:0], 1'b0};
          end else if (idx == IDX_W'(HDR_W)) begin
            bit_v    = rd_data[DAT_W-1];
            dat_sr_n = {rd_data[DAT_W-2:0], 1'b0};
          end else begin
            bit_v    = dat_sr[DAT_W-1];
            dat_sr_n = {dat_sr[DAT_W-2:0], 1'b0};
          end
          dout_n = bit_v & rep_q;
          if (idx == IDX_W'(FRM_W - 1)) st_n = TX_TAIL;
          else                          idx_n = idx + 1'b1;
        end
      end
      TX_TAIL: begin
        if (rise) begin
          st_n   = TX_IDLE;
          dout_n = 1'b0;
          oe_n   = 1'b0;
        end
      end
      default: st_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TX_IDLE;
      idx     <= '0;
      echo_sr <= '0;
      dat_sr  <= '0;
      rep_q   <= 1'b0;
      dout    <= 1'b0;
      oe      <= 1'b0;
    end else begin
      st      <= st_n;
      idx     <= idx_n;
      echo_sr <= echo_sr_n;
      dat_sr  <= dat_sr_n;
      rep_q   <= rep_n;
      dout    <= dout_n;
      oe      <= oe_n;
    end
  end

  assign sdout = dout;
  assign soe   = oe;
  assign tail  = (st == TX_TAIL);
endmodule

// File: rtl/crate_cmd_slave.sv
module crate_cmd_slave
  import ccs_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter logic [NSEC-1:0] RSVD_MASK   = NSEC'(1 << 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_din,
  input  logic [SEL_W-1:0] board_id,
  input  logic [DAT_W-1:0] rd_data,
  output logic             ser_dout,
  output logic             ser_oe,
  output logic [NSEC-1:0]  wr_stb,
  output logic [NSEC-1:0]  rd_stb,
  output logic [DAT_W-1:0] wr_data,
  output logic             pwr_down
);
  logic [1:0]        rst_q;
  logic              rst_ns;
  logic              sclk_rise, sdin_s;
  logic              frame_vld, tx_tail;
  cmd_frame_t        frame;
  logic              tx_start, tx_reply;
  logic [ECHO_W-1:0] tx_echo;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ns = rst_q[1];

  ccs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .sclk_a(ser_clk), .sdin_a(ser_din),
    .sclk_rise(sclk_rise), .sdin_s(sdin_s)
  );

  ccs_rx u_rx (
    .clk(clk), .rst_n(rst_ns), .rise(sclk_rise), .sdin(sdin_s),
    .tx_tail(tx_tail), .frame_vld(frame_vld), .frame(frame)
  );

  ccs_decode #(.RSVD_MASK(RSVD_MASK)) u_dec (
    .clk(clk), .rst_n(rst_ns), .frame_vld(frame_vld), .frame(frame),
    .board_id(board_id), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_data(wr_data), .pwr_down(pwr_down), .tx_start(tx_start),
    .tx_reply(tx_reply), .tx_echo(tx_echo)
  );

  ccs_tx u_tx (
    .clk(clk), .rst_n(rst_ns), .rise(sclk_rise), .start(tx_start),
    .reply(tx_reply), .echo(tx_echo), .rd_data(rd_data),
    .sdout(ser_dout), .soe(ser_oe), .tail(tx_tail)
  );
endmodule

// File: rtl/crate_cmd_slave_chk.sv
module crate_cmd_slave_chk
  import ccs_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            sclk_rise,
  input logic            ser_oe,
  input logic            ser_dout,
  input logic [NSEC-1:0] wr_stb,
  input logic [NSEC-1:0] rd_stb
);
  logic any_stb;
  assign any_stb = |{wr_stb, rd_stb};

  assert_stb_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_stb}));

  assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |=> !any_stb);

  assert_no_stb_while_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> !ser_oe);

  assert_oe_rise_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_oe) |-> $past(sclk_rise));

  assert_oe_fall_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_oe) |-> $past(sclk_rise));

  assert_reply_starts_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_oe) |-> !ser_dout);

  assert_dout_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(ser_dout));

  assert_quiet_when_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> !ser_dout);
endmodule

bind crate_cmd_slave crate_cmd_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .ser_oe(ser_oe),
  .ser_dout(ser_dout), .wr_stb(wr_stb), .rd_stb(rd_stb)
);

// File: tb/sim_crate_cmd_slave.sv
`timescale 1ns/1ps
module sim_crate_cmd_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic [7:0]  board_id = 8'h5A;
  logic [15:0] rd_data = 16'h0000;
  logic        ser_dout, ser_oe, pwr_down;
  logic [7:0]  wr_stb, rd_stb;
  logic [15:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;
  int n_wr = 0;
  int n_rd = 0;
  logic [7:0]  last_wr_stb = '0;
  logic [7:0]  last_rd_stb = '0;
  logic [15:0] last_wr_data = '0;

  always #2.5 clk = ~clk;

  crate_cmd_slave u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .board_id(board_id), .rd_data(rd_data), .ser_dout(ser_dout),
    .ser_oe(ser_oe), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_data(wr_data), .pwr_down(pwr_down)
  );

  always @(posedge clk) begin
    if (|wr_stb) begin n_wr++; last_wr_stb <= wr_stb; last_wr_data <= wr_data; end
    if (|rd_stb) begin n_rd++; last_rd_stb <= rd_stb; end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic pd, input logic bc, input logic [7:0] sel,
                                      input logic rw, input logic [2:0] sec, input logic [15:0] d,
                                      input logic bad);
    logic [29:0] body;
    logic        p;
    body = {pd, bc, sel, rw, sec, d};
    p    = ~(^body) ^ bad;
    return {1'b1, p, body};
  endfunction

  task automatic tick(input logic b, output logic sd, output logic so);
    @(negedge clk) ser_din = b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (8) @(negedge clk);
    sd = ser_dout;
    so = ser_oe;
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Full transaction: 32 command bits, 32 reply edges, one idle edge.
  task automatic run_frame(input logic [31:0] f, input logic [15:0] rdv, input logic [31:0] txd,
                           output logic [31:0] rep, output int oe_cnt, output logic oe_after);
    logic sd, so;
    rd_data = rdv;
    oe_cnt = 0;
    rep = '0;
    for (int i = 31; i >= 0; i--) tick(f[i], sd, so);
    for (int i = 31; i >= 0; i--) begin
      tick(txd[i], sd, so);
      rep[i] = sd;
      if (so) oe_cnt++;
    end
    tick(1'b0, sd, so);
    oe_after = so;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11", "oe after reset", {31'd0, ser_oe}, 32'd0);
    chk("R11", "dout after reset", {31'd0, ser_dout}, 32'd0);
    chk("R11", "strobes after reset", {16'd0, wr_stb, rd_stb}, 32'd0);
    chk("R11", "pwr_down after reset", {31'd0, pwr_down}, 32'd0);
  endtask

  task automatic t_write;
    logic [31:0] f, rep; int oc; logic oa; int w0;
    w0 = n_wr;
    f = mk(1'b0, 1'b0, 8'h5A, 1'b0, 3'd1, 16'hA5C3, 1'b0);
    run_frame(f, 16'h1E0F, 32'h0, rep, oc, oa);
    chk("R5", "write strobe count", n_wr - w0, 1);
    chk("R5", "write strobe section", {24'd0, last_wr_stb}, 32'h02);
    chk("R2", "write data field", {16'd0, last_wr_data}, 32'hA5C3);
    chk("R7", "write reply word", rep, {1'b0, f[30:16], 16'h1E0F});
    chk("R8", "oe edges on reply", oc, 32);
    chk("R8", "oe released after reply", {31'd0, oa}, 32'd0);
  endtask

  task automatic t_read;
    logic [31:0] f, rep; int oc; logic oa; int w0, r0;
    w0 = n_wr; r0 = n_rd;
    f = mk(1'b0, 1'b0, 8'h5A, 1'b1, 3'd7, 16'h0000, 1'b0);
    run_frame(f, 16'hC0DE, 32'h0, rep, oc, oa);
    chk("R5", "read strobe count", n_rd - r0, 1);
    chk("R5", "read strobe section", {24'd0, last_rd_stb}, 32'h80);
    chk("R12", "no write strobe on read", n_wr - w0, 0);
    chk("R7", "read reply word", rep, {1'b0, f[30:16], 16'hC0DE});
  endtask

  task automatic t_idle_zeros;
    logic sd, so; int w0;
    w0 = n_wr;
    for (int i = 0; i < 12; i++) tick(1'b0, sd, so);
    chk("R1", "zeros start nothing", n_wr - w0 + n_rd, n_rd);
    chk("R1", "oe low while idle", {31'd0, so}, 32'd0);
  endtask

  task automatic t_parity;
    logic [31:0] f, rep; int oc; logic oa; int w0;
    w0 = n_wr;
    f = mk(1'b0, 1'b0, 8'h5A, 1'b0, 3'd2, 16'h1234, 1'b1);
    run_frame(f, 16'hFFFF, 32'h0, rep, oc, oa);
    chk("R3", "bad parity no strobe", n_wr - w0, 0);
    chk("R3", "bad parity no reply", oc, 0);
    chk("R3", "bad parity line quiet", rep, 32'd0);
  endtask

  task automatic t_mismatch;
    logic [31:0] f, look, rep; int oc; logic oa; int w0;
    w0 = n_wr;
    f    = mk(1'b0, 1'b0, 8'h5B, 1'b0, 3'd3, 16'h4444, 1'b0);
    // Valid-looking frame for this slave sent during the reply window.
    look = mk(1'b0, 1'b0, 8'h5A, 1'b0, 3'd0, 16'h7777, 1'b0);
    run_frame(f, 16'hFFFF, look, rep, oc, oa);
    chk("R4", "mismatch no strobe", n_wr - w0, 0);
    chk("R4", "mismatch no reply", oc, 0);
    chk("R1", "reply-window data ignored", n_wr - w0, 0);
  endtask

  task automatic t_bcast;
    logic [31:0] f, rep; int oc; logic oa; int w0, r0;
    w0 = n_wr; r0 = n_rd;
    f = mk(1'b0, 1'b1, 8'h00, 1'b0, 3'd5, 16'hBEEF, 1'b0);
    run_frame(f, 16'hFFFF, 32'h0, rep, oc, oa);
    chk("R6", "broadcast write strobe", n_wr - w0, 1);
    chk("R6", "broadcast write section", {24'd0, last_wr_stb}, 32'h20);
    chk("R6", "broadcast write no reply", oc, 0);
    f = mk(1'b0, 1'b1, 8'h5A, 1'b1, 3'd6, 16'h0000, 1'b0);
    run_frame(f, 16'hFFFF, 32'h0, rep, oc, oa);
    chk("R6", "broadcast read no strobe", n_rd - r0, 0);
    chk("R6", "broadcast read no reply", oc, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] f, rep; int oc; logic oa; int w0;
    w0 = n_wr;
    f = mk(1'b0, 1'b0, 8'h5A, 1'b0, 3'd4, 16'h9999, 1'b0);
    run_frame(f, 16'h8001, 32'h0, rep, oc, oa);
    chk("R9", "reserved section no strobe", n_wr - w0, 0);
    chk("R9", "reserved section replies", rep, {1'b0, f[30:16], 16'h8001});
  endtask

  task automatic t_pwr;
    logic [31:0] f, rep; int oc; logic oa;
    f = mk(1'b1, 1'b0, 8'h5A, 1'b0, 3'd0, 16'h0001, 1'b0);
    run_frame(f, 16'h0, 32'h0, rep, oc, oa);
    chk("R10", "pwr_down set by accepted frame", {31'd0, pwr_down}, 32'd1);
    f = mk(1'b0, 1'b0, 8'h5A, 1'b0, 3'd0, 16'h0002, 1'b1);
    run_frame(f, 16'h0, 32'h0, rep, oc, oa);
    chk("R3", "pwr_down kept on bad parity", {31'd0, pwr_down}, 32'd1);
    f = mk(1'b0, 1'b1, 8'h11, 1'b0, 3'd0, 16'h0003, 1'b0);
    run_frame(f, 16'h0, 32'h0, rep, oc, oa);
    chk("R10", "pwr_down cleared by broadcast write", {31'd0, pwr_down}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_idle_zeros();
    t_write();
    t_read();
    t_parity();
    t_mismatch();
    t_bcast();
    t_reserved();
    t_pwr();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule